// File: doc/BRIEF.md
# Parallel Port Control Register

This block holds the host-writable control byte of a PC-style parallel port. The host reaches it over a plain 8-bit register bus. That bus has an address, a one-cycle write strobe and a read strobe. The stored bits set the four printer handshake outputs, each with its own polarity. They also choose the direction of the data lines and enable the port interrupt.

The port's operating mode comes in on a two-bit input: 00 printer, 01 bidirectional, 10 EPP, 11 ECP. In printer mode the data lines always stay outputs, whatever the direction bit holds. The acknowledge input from the printer passes through a two-flop synchronizer. When the interrupt is enabled, each rising edge of acknowledge produces a one-clock interrupt pulse.

Readback returns the stored bits and not the pin levels. The two top bits of the register are fixed at zero.

Top module: `pport_ctrl`

## Requirements
- R1: While reset is low and after it is released, strobe_n, autofd_n and selectin_n are 1, init_n is 0, pd_input is 0, irq is 0 and the register reads back as 0x00.
- R2: After a write to the control address (offset 2), strobe_n from the next cycle is the inverse of written bit 0, and autofd_n is the inverse of written bit 1.
- R3: After a control write, init_n from the next cycle equals written bit 2, with no inversion.
- R4: After a control write, selectin_n from the next cycle is the inverse of written bit 3, so writing 1 selects the printer by driving it low.
- R5: In modes 01, 10 and 11, pd_input equals stored bit 5 (1 = data lines are inputs, 0 = outputs).
- R6: In mode 00 (printer), pd_input is 0 regardless of stored bit 5.
- R7: With stored bit 4 set, a rising edge of ack_n_in makes irq high for exactly one clock. The pulse appears in the third clock cycle after the first edge that samples ack_n_in high.
- R8: With stored bit 4 clear, irq stays 0 on every edge of ack_n_in. A falling edge of ack_n_in never raises irq.
- R9: A read of the control address returns stored bits 0 to 5 in bits 0 to 5, whatever the mode and the pin levels, with bits 6 and 7 always 0.
- R10: A write to any other address leaves the register and every output unchanged. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| mode | input | 2 | Port mode: 00 printer, 01 bidir, 10 EPP, 11 ECP |
| ack_n_in | input | 1 | Acknowledge from the printer, asynchronous |
| strobe_n | output | 1 | Data strobe pin level |
| autofd_n | output | 1 | Auto line feed pin level |
| init_n | output | 1 | Initialize pin level |
| selectin_n | output | 1 | Printer select pin level |
| pd_input | output | 1 | Data line direction, 1 = input |
| irq | output | 1 | Port interrupt pulse |

## Verification
Several rules are checked by the assertions on every cycle. These are the per-bit pin polarity after each control write, the printer-mode direction override, the zero top bits on readback, and that irq is a single-cycle pulse seen only while the enable was stored. Other behaviour can only be shown by the bench's scenarios. That covers the exact synchronizer latency from an acknowledge edge to the pulse, and the edges that are lost while the enable is clear. It also covers the readback of a direction bit that printer mode hides, and the ignoring of other addresses.

// File: rtl/pport_ctrl_pkg.sv
// Shared types for the parallel port control register.
// Assumes a two-bit mode code supplied by the port's mode logic.
package pport_ctrl_pkg;

    typedef enum logic [1:0] {
        MODE_PRINTER = 2'b00,
        MODE_BIDIR   = 2'b01,
        MODE_EPP     = 2'b10,
        MODE_ECP     = 2'b11
    } port_mode_t;

    // Field positions inside the stored control bits
    localparam int unsigned BIT_STROBE = 0;
    localparam int unsigned BIT_AUTOFD = 1;
    localparam int unsigned BIT_INIT   = 2;
    localparam int unsigned BIT_SELECT = 3;
    localparam int unsigned BIT_IRQEN  = 4;
    localparam int unsigned BIT_DIR    = 5;
    localparam int unsigned CTRL_W     = 6;

endpackage

// File: rtl/pport_ctrl_reg.sv
// Storage of the writable control bits and their readback path.
// Assumes bus_wr is a one-cycle strobe. Reads are combinational while bus_rd is high.
module pport_ctrl_reg
    import pport_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_W    = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 3'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CTRL_W-1:0] ctrl_q
);

    localparam int unsigned PAD_W = DATA_W - CTRL_W;

    logic addr_hit;
    logic unused_wdata;

    assign addr_hit     = (bus_addr == CTRL_ADDR);
    assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_W];

    // Capture the low control bits on a write to the control offset
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (bus_wr && addr_hit)
            ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    // Present stored bits with zero padding while the control offset is read
    always_comb begin
        if (bus_rd && addr_hit)
            bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
        else
            bus_rdata = '0;
    end

endmodule

// File: rtl/pport_pin_map.sv
// Maps stored control bits to pin levels with per-bit polarity, and
// resolves data direction against the port mode.
// Purely combinational. Assumes ctrl_q is a registered value.
module pport_pin_map
    import pport_ctrl_pkg::*;
#(
    parameter int unsigned PIN_N    = 4,
    parameter logic [PIN_N-1:0] INV_MASK = 4'b1011
) (
    input  logic [CTRL_W-1:0] ctrl_q,
    input  port_mode_t        mode,
    output logic [PIN_N-1:0]  pins,
    output logic              pd_input
);

    // One polarity stage per handshake pin, chosen by INV_MASK
    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        if (INV_MASK[i]) begin : g_inv
            assign pins[i] = ~ctrl_q[i];
        end else begin : g_direct
            assign pins[i] = ctrl_q[i];
        end
    end

    // Printer mode forces the data lines to drive out
    always_comb begin
        pd_input = (mode == MODE_PRINTER) ? 1'b0 : ctrl_q[BIT_DIR];
    end

endmodule

// File: rtl/pport_ack_irq.sv
// Synchronizes the acknowledge input and emits a one-clock interrupt
// pulse per rising edge while enabled.
// Assumes ack_n_in is asynchronous and idles high. SYNC_STAGES >= 2.
module pport_ack_irq #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_in,
    input  logic irq_en,
    output logic irq
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ack_prev_q;
    logic                   ack_rise;

    // Shift the asynchronous input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '1;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], ack_n_in};
    end

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_prev_q <= 1'b1;
        else
            ack_prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign ack_rise = sync_q[SYNC_STAGES-1] & ~ack_prev_q;

    // Register the gated edge as a single-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= ack_rise & irq_en;
    end

endmodule

// File: rtl/pport_ctrl.sv
// Top of the parallel port control register: storage, pin mapping,
// and acknowledge interrupt.
// Assumes a single clock domain for the host bus. Only ack_n_in is asynchronous.
module pport_ctrl
    import pport_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 3'd2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        mode,
    input  logic              ack_n_in,
    output logic              strobe_n,
    output logic              autofd_n,
    output logic              init_n,
    output logic              selectin_n,
    output logic              pd_input,
    output logic              irq
);

    localparam int unsigned PIN_N = 4;

    logic [CTRL_W-1:0] ctrl_q;
    logic [PIN_N-1:0]  pins;
    port_mode_t        mode_e;

    assign mode_e = port_mode_t'(mode);

    pport_ctrl_reg #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .ctrl_q    (ctrl_q)
    );

    pport_pin_map #(
        .PIN_N    (PIN_N),
        .INV_MASK (4'b1011)
    ) u_map (
        .ctrl_q   (ctrl_q),
        .mode     (mode_e),
        .pins     (pins),
        .pd_input (pd_input)
    );

    pport_ack_irq #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_n_in (ack_n_in),
        .irq_en   (ctrl_q[BIT_IRQEN]),
        .irq      (irq)
    );

    assign strobe_n   = pins[BIT_STROBE];
    assign autofd_n   = pins[BIT_AUTOFD];
    assign init_n     = pins[BIT_INIT];
    assign selectin_n = pins[BIT_SELECT];

endmodule

// File: rtl/pport_ctrl_chk.sv
// Assertion checker for pport_ctrl, attached with bind.
// Assumes synchronous active-low reset. All checks are disabled while in reset.
module pport_ctrl_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 3'd2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [1:0]        mode,
    input logic              strobe_n,
    input logic              autofd_n,
    input logic              init_n,
    input logic              selectin_n,
    input logic              pd_input,
    input logic              irq,
    input logic [5:0]        ctrl_q
);

    logic wr_hit;
    assign wr_hit = bus_wr && (bus_addr == CTRL_ADDR);

    // R2
    strobe_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (strobe_n == !$past(bus_wdata[0])) && (autofd_n == !$past(bus_wdata[1])));

    // R3
    init_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (init_n == $past(bus_wdata[2])));

    // R4
    select_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (selectin_n == !$past(bus_wdata[3])));

    // R6
    printer_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> !pd_input);

    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ctrl_q[4]));

    // R9
    rd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:6] == 2'b00);

endmodule

bind pport_ctrl pport_ctrl_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .mode       (mode),
    .strobe_n   (strobe_n),
    .autofd_n   (autofd_n),
    .init_n     (init_n),
    .selectin_n (selectin_n),
    .pd_input   (pd_input),
    .irq        (irq),
    .ctrl_q     (ctrl_q)
);

// File: tb/tb_pport_ctrl.sv
// Directed bench for pport_ctrl: one task per scenario, each checking its results.
`timescale 1ns/1ps
module tb_pport_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [1:0] mode = 2'b00;
    logic       ack_n_in = 1'b1;
    logic       strobe_n, autofd_n, init_n, selectin_n, pd_input, irq;

    int checks = 0;
    int fails  = 0;

    localparam logic [2:0] CA = 3'd2;

    always #2.5 clk = ~clk;

    pport_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .mode(mode),
        .ack_n_in(ack_n_in), .strobe_n(strobe_n), .autofd_n(autofd_n),
        .init_n(init_n), .selectin_n(selectin_n), .pd_input(pd_input), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 strobe_n", {7'd0, strobe_n}, 8'd1);
        check("R1 irq", {7'd0, irq}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pins", {3'd0, strobe_n, autofd_n, init_n, selectin_n, pd_input}, 8'b11010);
        bus_read(CA, d);
        check("R1 readback", d, 8'h00);
    endtask

    task automatic t_handshake_pins;
        bus_write(CA, 8'h03);
        check("R2 strobe/autofd set", {6'd0, strobe_n, autofd_n}, 8'b00);
        bus_write(CA, 8'h01);
        check("R2 strobe only", {6'd0, strobe_n, autofd_n}, 8'b01);
        bus_write(CA, 8'h04);
        check("R3 init direct high", {7'd0, init_n}, 8'd1);
        check("R2 pins released", {6'd0, strobe_n, autofd_n}, 8'b11);
        bus_write(CA, 8'h08);
        check("R3 init low", {7'd0, init_n}, 8'd0);
        check("R4 select low", {7'd0, selectin_n}, 8'd0);
        bus_write(CA, 8'h00);
        check("R4 select high", {7'd0, selectin_n}, 8'd1);
    endtask

    task automatic t_direction;
        logic [7:0] d;
        bus_write(CA, 8'h20);
        mode = 2'b01; #1 check("R5 bidir input", {7'd0, pd_input}, 8'd1);
        mode = 2'b10; #1 check("R5 epp input", {7'd0, pd_input}, 8'd1);
        mode = 2'b11; #1 check("R5 ecp input", {7'd0, pd_input}, 8'd1);
        mode = 2'b00; #1 check("R6 printer forced out", {7'd0, pd_input}, 8'd0);
        bus_read(CA, d);
        check("R9 dir bit visible in printer mode", d, 8'h20);
        mode = 2'b01;
        bus_write(CA, 8'h00);
        check("R5 bidir output", {7'd0, pd_input}, 8'd0);
        mode = 2'b00;
    endtask

    task automatic t_irq_enabled;
        int pulses;
        bus_write(CA, 8'h10);
        @(negedge clk); ack_n_in = 1'b0;
        repeat (5) @(negedge clk);
        ack_n_in = 1'b1;
        @(negedge clk); check("R7 no irq cycle1", {7'd0, irq}, 8'd0);
        @(negedge clk); check("R7 no irq cycle2", {7'd0, irq}, 8'd0);
        @(negedge clk); check("R7 irq cycle3", {7'd0, irq}, 8'd1);
        @(negedge clk); check("R7 irq one clock", {7'd0, irq}, 8'd0);
        pulses = 0;
        ack_n_in = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        check("R8 falling edge no irq", pulses[7:0], 8'd0);
    endtask

    task automatic t_irq_disabled;
        int pulses;
        bus_write(CA, 8'h00);
        repeat (4) @(negedge clk);
        pulses = 0;
        ack_n_in = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        check("R8 disabled no irq", pulses[7:0], 8'd0);
    endtask

    task automatic t_readback_and_other;
        logic [7:0] d;
        bus_write(CA, 8'hFF);
        bus_read(CA, d);
        check("R9 top bits zero", d, 8'h3F);
        bus_write(3'd0, 8'h00);
        bus_write(3'd3, 8'h00);
        check("R10 pins unchanged", {3'd0, strobe_n, autofd_n, init_n, selectin_n, pd_input}, 8'b00100);
        bus_read(CA, d);
        check("R10 register unchanged", d, 8'h3F);
        bus_read(3'd5, d);
        check("R10 other address reads zero", d, 8'h00);
        bus_write(CA, 8'h15);
        bus_read(CA, d);
        check("R9 stored pattern", d, 8'h15);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_handshake_pins();
        t_direction();
        t_irq_enabled();
        t_irq_disabled();
        t_readback_and_other();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule